// File: doc/BRIEF.md
# Flash control register guard

This block holds two byte-wide control registers for an on-chip flash controller and sits on a simple byte bus. The bus has an address, a write strobe, write data and read data. Some bits may change only through a two-write handshake: a first write stages a value, and the change happens only if the very next write to the same register completes the pair. This guards the flash against stray single writes. The block-lock bits and the mode bit also depend on a rewrite-enable input from the flash controller. They are held at zero whenever that input is low.

The second register carries the erase-suspend logic. An erase-busy input from the flash sequencer and a suspend-enable bit together open a "suspend window". Inside that window the suspend request behaves in one of two ways. In the software-driven mode, firmware may set or clear it. In the interrupt-driven mode, a maskable interrupt sets it and firmware may only clear it. A read-status flag from the sequencer is shown on a read-only bit.

The bus carries single register accesses, not a stream, so it has no valid/ready handshake. Every write is taken in the cycle its strobe is high. Read data is a combinational decode of the address and has no back-pressure.

Top module: `fcg_regs`

## Requirements
- R1: After reset the mode register (address 0x1B5) reads 0x80 and the suspend register (address 0x1B3) reads 0x40 while the read-status input is 1. All four control outputs are 0.
- R2: The mode bit (mode register bit 1, 1 = interrupt-driven mode) becomes 1 only on a write with bit 1 = 1 that directly follows a write to the same register with bit 1 = 0, with rewrite-enable high. A lone write of 1 leaves it unchanged. A write with bit 1 = 0 clears it.
- R3: With rewrite-enable high, the lock bits (bit 5 locks block 0, bit 6 locks block 1) are set by a single write of 1. A lock bit clears only on a write of 0 that directly follows a write to the mode register carrying 1 in that bit. A lone 0 leaves it set.
- R4: One cycle after rewrite-enable is sampled low, the mode bit and both lock bits are 0. They stay 0 while it is low, and writes to them are ignored.
- R5: A write to any other address between the two steps of a pair cancels the pending first step.
- R6: The suspend-enable bit (suspend register bit 0) becomes 1 only on a write of 1 that directly follows a write of 0 to that register. A write of 0 clears it.
- R7: The suspend request (suspend register bit 1, and the output pin) is 0 whenever suspend-enable or erase-busy is 0. Writes to it outside that window have no effect.
- R8: In software-driven mode (mode bit 0), a write inside the window loads bit 1 into the suspend request. A maskable interrupt has no effect.
- R9: In interrupt-driven mode, an interrupt inside the window sets the suspend request at the next edge, and wins over a clearing write in the same cycle. A write of 0 clears the request and a write of 1 is ignored.
- R10: Reserved bits read as fixed values: mode register bit 7 reads 1, and mode register bits 4..2 and 0 read 0. Suspend register bits 7 and 5..2 read 0, and bit 6 shows the read-status input live. Writes to these bits are discarded.
- R11: Any address other than the two registers reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| rewrite_en_i | input | 1 | Flash rewrite enabled; low forces the mode and lock bits to 0 |
| erase_busy_i | input | 1 | Erase in progress, from the flash sequencer |
| irq_req_i | input | 1 | Maskable interrupt pending |
| rd_ok_i | input | 1 | Flash readable status from the sequencer |
| ew1_mode_o | output | 1 | 1 = interrupt-driven suspend mode |
| blk0_lock_o | output | 1 | Block 0 rewrite disabled |
| blk1_lock_o | output | 1 | Block 1 rewrite disabled |
| susp_req_o | output | 1 | Erase-suspend request to the sequencer |

## Verification
A write updates its register at the clock edge that samples the strobe. The new value appears on the read port and the control pins right after that edge. A low rewrite-enable or an interrupt in the window acts at the next edge as well. The suspend pin and its read bit fall in the same cycle that erase-busy or suspend-enable drops, because the window masks them combinationally. The bench drives each cycle's inputs two nanoseconds after an edge and samples one nanosecond after the following edge. It then sweeps the address over both registers to read them back, so every result is compared in the first cycle it is due.

// File: rtl/fcg_pkg.sv
`timescale 1ns/100ps
package fcg_pkg;
  localparam int BYTE_W     = 8;
  // Mode register bit positions
  localparam int MODE_EW1_B = 1;
  localparam int MODE_LK0_B = 5;
  localparam int MODE_LK1_B = 6;
  localparam int MODE_ONE_B = 7;
  localparam int LOCK_N     = 2;
  // Suspend register bit positions
  localparam int SUSP_EN_B  = 0;
  localparam int SUSP_REQ_B = 1;
  localparam int SUSP_RDY_B = 6;

  typedef enum logic {MODE_SW_SUSP = 1'b0, MODE_IRQ_SUSP = 1'b1} susp_mode_e;
endpackage

// File: rtl/fcg_step_track.sv
`timescale 1ns/100ps
// Remembers the previous write to one register; any write elsewhere cancels it.
module fcg_step_track #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic         hit,
  input  logic [W-1:0] wbits,
  output logic         prv_vld,
  output logic [W-1:0] prv_bits
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prv_vld  <= 1'b0;
      prv_bits <= '0;
    end else if (bus_we) begin
      prv_vld <= hit;
      if (hit) prv_bits <= wbits;
    end
  end

  assert_cancel_on_foreign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> !prv_vld);
endmodule

// File: rtl/fcg_mode_reg.sv
`timescale 1ns/100ps
// Mode bit and block-lock bits, gated by rewrite-enable.
module fcg_mode_reg
  import fcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rewrite_en,
  input  logic              wr_hit,
  input  logic [LOCK_N:0]   wbits,     // {lk1, lk0, ew1}
  input  logic              prv_vld,
  input  logic [LOCK_N:0]   prv_bits,
  output logic              ew1_q,
  output logic [LOCK_N-1:0] lock_q
);
  logic ew1_pair;
  assign ew1_pair = prv_vld && !prv_bits[0];

  always_ff @(posedge clk) begin
    if (!rst_n || !rewrite_en) ew1_q <= 1'b0;
    else if (wr_hit)           ew1_q <= wbits[0] && (ew1_q || ew1_pair);
  end

  for (genvar g = 0; g < LOCK_N; g++) begin : g_lock
    logic clr_pair;
    assign clr_pair = prv_vld && prv_bits[g+1];
    always_ff @(posedge clk) begin
      if (!rst_n || !rewrite_en) lock_q[g] <= 1'b0;
      else if (wr_hit) begin
        if (wbits[g+1])    lock_q[g] <= 1'b1;
        else if (clr_pair) lock_q[g] <= 1'b0;
      end
    end

    assert_lock_clear_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lock_q[g]) && $past(rewrite_en)) |->
        $past(wr_hit && !wbits[g+1] && prv_vld && prv_bits[g+1]));
  end

  assert_ew1_needs_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ew1_q) |-> $past(wr_hit && wbits[0] && prv_vld && !prv_bits[0] && rewrite_en));

  assert_drop_on_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rewrite_en |=> (!ew1_q && lock_q == '0));
endmodule

// File: rtl/fcg_susp_reg.sv
`timescale 1ns/100ps
// Suspend-enable and suspend-request logic.
module fcg_susp_reg
  import fcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic erase_busy,
  input  logic irq_req,
  input  logic ew1,
  input  logic wr_hit,
  input  logic w_en,
  input  logic w_req,
  input  logic prv_vld,
  input  logic prv_en,
  output logic en_q,
  output logic req_o
);
  susp_mode_e mode;
  logic       window;
  logic       req_q;

  assign mode   = susp_mode_e'(ew1);
  assign window = en_q && erase_busy;
  assign req_o  = req_q && window;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_hit) en_q <= w_en && (en_q || (prv_vld && !prv_en));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !window) req_q <= 1'b0;
    else begin
      case (mode)
        MODE_IRQ_SUSP: begin
          if (irq_req)              req_q <= 1'b1;
          else if (wr_hit && !w_req) req_q <= 1'b0;
        end
        default: begin
          if (wr_hit) req_q <= w_req;
        end
      endcase
    end
  end

  assert_en_needs_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(wr_hit && w_en && prv_vld && !prv_en));

  assert_closed_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_q && erase_busy) |=> !req_q);

  assert_sw_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !ew1 && en_q && erase_busy) |=> (req_q == $past(w_req)));

  assert_irq_only_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && $past(ew1)) |-> $past(irq_req));
endmodule

// File: rtl/fcg_regs.sv
`timescale 1ns/100ps
module fcg_regs
  import fcg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h01B5,
  parameter logic [ADDR_W-1:0] SUSP_ADDR = 16'h01B3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rewrite_en_i,
  input  logic              erase_busy_i,
  input  logic              irq_req_i,
  input  logic              rd_ok_i,
  output logic              ew1_mode_o,
  output logic              blk0_lock_o,
  output logic              blk1_lock_o,
  output logic              susp_req_o
);
  localparam int MODE_TW = LOCK_N + 1;

  logic               sel_mode, sel_susp, hit_mode, hit_susp;
  logic [MODE_TW-1:0] mode_wbits, mode_prv_bits;
  logic               mode_prv_vld;
  logic               susp_prv_vld, susp_prv_en;
  logic               ew1_q, en_q, req_vis;
  logic [LOCK_N-1:0]  lock_q;
  logic               unused_wbits;

  assign sel_mode = (bus_addr == MODE_ADDR);
  assign sel_susp = (bus_addr == SUSP_ADDR);
  assign hit_mode = bus_we && sel_mode;
  assign hit_susp = bus_we && sel_susp;

  assign mode_wbits   = {bus_wdata[MODE_LK1_B], bus_wdata[MODE_LK0_B], bus_wdata[MODE_EW1_B]};
  assign unused_wbits = ^{bus_wdata[7], bus_wdata[4:2], bus_wdata[0]};

  fcg_step_track #(.W(MODE_TW)) u_mode_trk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .hit(hit_mode),
    .wbits(mode_wbits), .prv_vld(mode_prv_vld), .prv_bits(mode_prv_bits)
  );

  fcg_step_track #(.W(1)) u_susp_trk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .hit(hit_susp),
    .wbits(bus_wdata[SUSP_EN_B]), .prv_vld(susp_prv_vld), .prv_bits(susp_prv_en)
  );

  fcg_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .rewrite_en(rewrite_en_i), .wr_hit(hit_mode),
    .wbits(mode_wbits), .prv_vld(mode_prv_vld), .prv_bits(mode_prv_bits),
    .ew1_q(ew1_q), .lock_q(lock_q)
  );

  fcg_susp_reg u_susp (
    .clk(clk), .rst_n(rst_n), .erase_busy(erase_busy_i), .irq_req(irq_req_i),
    .ew1(ew1_q), .wr_hit(hit_susp), .w_en(bus_wdata[SUSP_EN_B]),
    .w_req(bus_wdata[SUSP_REQ_B]), .prv_vld(susp_prv_vld), .prv_en(susp_prv_en),
    .en_q(en_q), .req_o(req_vis)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_mode) begin
      bus_rdata[MODE_ONE_B] = 1'b1;
      bus_rdata[MODE_LK1_B] = lock_q[1];
      bus_rdata[MODE_LK0_B] = lock_q[0];
      bus_rdata[MODE_EW1_B] = ew1_q;
    end else if (sel_susp) begin
      bus_rdata[SUSP_RDY_B] = rd_ok_i;
      bus_rdata[SUSP_REQ_B] = req_vis;
      bus_rdata[SUSP_EN_B]  = en_q;
    end
  end

  assign ew1_mode_o  = ew1_q;
  assign blk0_lock_o = lock_q[0];
  assign blk1_lock_o = lock_q[1];
  assign susp_req_o  = req_vis;

  assert_mode_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_mode |-> (bus_rdata[MODE_ONE_B] && bus_rdata[4:2] == 3'b000 && !bus_rdata[0]));
endmodule

// File: tb/fcg_regs_tb.sv
`timescale 1ns/100ps
module fcg_regs_tb;
  localparam logic [15:0] A_MODE = 16'h01B5;
  localparam logic [15:0] A_SUSP = 16'h01B3;
  localparam logic [15:0] A_OTHR = 16'h01B4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ren = 1'b0, busy = 1'b0, irq = 1'b0, rdok = 1'b1;
  logic        ew1_mode_o, blk0_lock_o, blk1_lock_o, susp_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit m_ew1, m_lk0, m_lk1, m_en, m_req;
  bit p1v, p2v;
  logic [7:0] p1d, p2d;

  always #2.5 clk = ~clk;

  fcg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rewrite_en_i(ren),
    .erase_busy_i(busy), .irq_req_i(irq), .rd_ok_i(rdok),
    .ew1_mode_o(ew1_mode_o), .blk0_lock_o(blk0_lock_o),
    .blk1_lock_o(blk1_lock_o), .susp_req_o(susp_req_o)
  );

  function automatic logic [7:0] exp_mode();
    return {1'b1, m_lk1, m_lk0, 3'b000, m_ew1, 1'b0};
  endfunction

  function automatic logic [7:0] exp_susp();
    return {1'b0, rdok, 4'b0000, m_req && m_en && busy, m_en};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_step(bit we, logic [15:0] a, logic [7:0] d, bit r, bit b, bit q);
    bit w1, w2, win, n_ew1, n_lk0, n_lk1, n_en, n_req;
    w1 = we && a == A_MODE;
    w2 = we && a == A_SUSP;
    win = m_en && b;
    n_ew1 = m_ew1; n_lk0 = m_lk0; n_lk1 = m_lk1; n_en = m_en; n_req = m_req;
    if (!r) begin
      n_ew1 = 0; n_lk0 = 0; n_lk1 = 0;
    end else if (w1) begin
      n_ew1 = d[1] && (m_ew1 || (p1v && !p1d[1]));
      if (d[5]) n_lk0 = 1; else if (p1v && p1d[5]) n_lk0 = 0;
      if (d[6]) n_lk1 = 1; else if (p1v && p1d[6]) n_lk1 = 0;
    end
    if (w2) n_en = d[0] && (m_en || (p2v && !p2d[0]));
    if (!win) n_req = 0;
    else if (m_ew1) begin
      if (q) n_req = 1; else if (w2 && !d[1]) n_req = 0;
    end else if (w2) n_req = d[1];
    if (we) begin
      p1v = w1; p2v = w2;
      if (w1) p1d = d;
      if (w2) p2d = d;
    end
    m_ew1 = n_ew1; m_lk0 = n_lk0; m_lk1 = n_lk1; m_en = n_en; m_req = n_req;
  endtask

  // One bus cycle: drive, let the edge pass, compare everything after it.
  task automatic cyc(bit we, logic [15:0] a, logic [7:0] d, bit r, bit b, bit q, bit rk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    ren = r; busy = b; irq = q; rdok = rk;
    @(posedge clk);
    model_step(we, a, d, r, b, q);
    #1;
    bus_we = 1'b0;
    bus_addr = A_MODE; #0.5;
    check("R10 mode readback", bus_rdata, exp_mode());
    bus_addr = A_SUSP; #0.5;
    check("R6 suspend readback", bus_rdata, exp_susp());
    check("R2 mode pin", {7'd0, ew1_mode_o}, {7'd0, m_ew1});
    check("R3 lock pins", {6'd0, blk1_lock_o, blk0_lock_o}, {6'd0, m_lk1, m_lk0});
    check("R9 suspend pin", {7'd0, susp_req_o}, {7'd0, m_req && m_en && busy});
  endtask

  task automatic rd(logic [15:0] a, string tag, logic [7:0] exp);
    bus_addr = a; #0.5;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(A_MODE, "R1 mode reset", 8'h80);
    rd(A_SUSP, "R1 suspend reset", 8'h40);
    check("R1 pins reset", {4'd0, ew1_mode_o, blk0_lock_o, blk1_lock_o, susp_req_o}, 8'h00);

    // R2
    cyc(1, A_MODE, 8'h02, 1, 0, 0, 1);
    check("R2 lone one", {7'd0, ew1_mode_o}, 8'h00);
    cyc(1, A_MODE, 8'h00, 1, 0, 0, 1);
    cyc(1, A_MODE, 8'h02, 1, 0, 0, 1);
    check("R2 pair sets", {7'd0, ew1_mode_o}, 8'h01);
    // R5
    cyc(1, A_MODE, 8'h00, 1, 0, 0, 1);
    cyc(1, A_OTHR, 8'h55, 1, 0, 0, 1);
    cyc(1, A_MODE, 8'h02, 1, 0, 0, 1);
    check("R5 foreign write cancels", {7'd0, ew1_mode_o}, 8'h00);
    // R3
    cyc(1, A_MODE, 8'h20, 1, 0, 0, 1);
    cyc(1, A_OTHR, 8'h00, 1, 0, 0, 1);
    cyc(1, A_MODE, 8'h00, 1, 0, 0, 1);
    check("R3 lone zero keeps lock", {7'd0, blk0_lock_o}, 8'h01);
    cyc(1, A_MODE, 8'h60, 1, 0, 0, 1);
    cyc(1, A_MODE, 8'h20, 1, 0, 0, 1);
    check("R3 pair clears block1 only", {6'd0, blk1_lock_o, blk0_lock_o}, 8'h01);
    // R4
    cyc(1, A_MODE, 8'h60, 1, 0, 0, 1);
    cyc(1, A_MODE, 8'h62, 1, 0, 0, 1);
    check("R4 all set before disable", {5'd0, ew1_mode_o, blk1_lock_o, blk0_lock_o}, 8'h07);
    cyc(0, A_MODE, 8'h00, 0, 0, 0, 1);
    check("R4 cleared on disable", {5'd0, ew1_mode_o, blk1_lock_o, blk0_lock_o}, 8'h00);
    cyc(1, A_MODE, 8'h62, 0, 0, 0, 1);
    check("R4 write ignored while disabled", {5'd0, ew1_mode_o, blk1_lock_o, blk0_lock_o}, 8'h00);
    // R6, R7
    cyc(1, A_SUSP, 8'h03, 1, 0, 0, 1);
    rd(A_SUSP, "R6 lone one", 8'h40);
    cyc(1, A_SUSP, 8'h00, 1, 0, 0, 1);
    cyc(1, A_SUSP, 8'h01, 1, 0, 0, 1);
    cyc(1, A_SUSP, 8'h03, 1, 0, 0, 1);
    rd(A_SUSP, "R7 request ignored when idle", 8'h41);
    // R8
    cyc(1, A_SUSP, 8'h03, 1, 1, 0, 1);
    check("R8 software set", {7'd0, susp_req_o}, 8'h01);
    cyc(1, A_SUSP, 8'h01, 1, 1, 0, 1);
    check("R8 software clear", {7'd0, susp_req_o}, 8'h00);
    cyc(1, A_SUSP, 8'h03, 1, 1, 0, 1);
    cyc(0, A_SUSP, 8'h00, 1, 0, 0, 1);
    rd(A_SUSP, "R7 masked when erase ends", 8'h41);
    cyc(0, A_SUSP, 8'h00, 1, 1, 1, 1);
    check("R8 interrupt ignored in software mode", {7'd0, susp_req_o}, 8'h00);
    // R9
    cyc(1, A_MODE, 8'h00, 1, 1, 0, 1);
    cyc(1, A_MODE, 8'h02, 1, 1, 0, 1);
    cyc(1, A_SUSP, 8'h03, 1, 1, 0, 1);
    check("R9 software set ignored", {7'd0, susp_req_o}, 8'h00);
    cyc(0, A_SUSP, 8'h00, 1, 1, 1, 1);
    check("R9 interrupt sets", {7'd0, susp_req_o}, 8'h01);
    cyc(1, A_SUSP, 8'h01, 1, 1, 0, 1);
    check("R9 software clear", {7'd0, susp_req_o}, 8'h00);
    cyc(1, A_SUSP, 8'h01, 1, 1, 1, 1);
    check("R9 interrupt beats clear", {7'd0, susp_req_o}, 8'h01);
    // R10
    cyc(1, A_SUSP, 8'hBD, 1, 1, 0, 0);
    rd(A_SUSP, "R10 suspend reserved bits", 8'h01);
    cyc(1, A_MODE, 8'h1D, 1, 0, 0, 1);
    rd(A_MODE, "R10 mode reserved bits", 8'h80);
    // R11
    cyc(1, A_OTHR, 8'hFF, 1, 0, 0, 1);
    rd(A_OTHR, "R11 unmapped read", 8'h00);
    rd(16'h0000, "R11 low unmapped read", 8'h00);
    rd(A_SUSP, "R11 no side effect", 8'h41);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      logic [15:0] a;
      op = $urandom % 8;
      a = (op < 3) ? A_MODE : (op < 6) ? A_SUSP : A_OTHR;
      cyc(op != 7, a, 8'($urandom), ($urandom % 10) != 0, ($urandom % 10) < 7,
          ($urandom % 5) == 0, ($urandom % 4) != 0);
    end
    if (seed == 0) $display("seed zero");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule